// File: doc/BRIEF.md
# Memory Pattern Self-Test Sequencer

This block is a self-test engine for a memory attached through a plain synchronous port. A pulse on `start_i` captures a base word address and a region length in 32-bit words. The engine then runs four test phases over that region, in a fixed order. In each phase it first writes every location of the region. Only after the last write does it read each location back and compare it. Reads go out one at a time. Each read waits for the memory's valid flag, so the engine works with any read latency.

The phases differ in access width and data. The first is a word checkerboard of two alternating complementary patterns. The second uses single bytes, each holding its own byte index. The third uses 16-bit halfwords, each holding its own halfword index. The fourth uses full words, each holding its own word index. When a phase has any mismatch, the engine still finishes the reads of that phase and then stops with a fail result. The first mismatch is kept for diagnosis.

States: `ST_IDLE` (waiting for start), `ST_WRITE` (one write per cycle), `ST_RD_REQ` (issue one read), `ST_RD_WAIT` (wait for read valid, then compare), `ST_PH_END` (decide between the next phase and finishing) and `ST_FINISH` (one-cycle done). Transitions:
- IDLE→WRITE on start with a non-zero length.
- IDLE→FINISH on start with a zero length.
- WRITE→RD_REQ after the last location.
- RD_REQ→RD_WAIT always.
- RD_WAIT→RD_REQ on valid when locations remain.
- RD_WAIT→PH_END on valid for the last location.
- PH_END→WRITE for a clean phase that is not the last.
- PH_END→FINISH on error or after the fourth phase.
- FINISH→IDLE always.

Top module: `mem_pattern_bist`

## Requirements
- R1: After reset, done, pass, write strobe and read strobe are all low. Start is sampled only in idle. A start pulse during a run has no effect on the run's result or timing.
- R2: The first phase writes every word of the region with full byte enables (4'b1111). Word offset i gets 0xAA55AA55 for even i and 0x55AA55AA for odd i. Every word is then read back and compared.
- R3: The second phase covers the region as bytes. Byte offset k goes to word base+k/4, lane k mod 4, with a single byte enable (bit k mod 4). The lane holds the low 8 bits of k, and the byte value is replicated on all four lanes of the write data. The read-back compare looks only at that lane.
- R4: The third phase covers the region as halfwords. Halfword offset h goes to word base+h/2. Even h uses enables 4'b0011 and odd h uses 4'b1100. The halfword holds the low 16 bits of h, replicated on both halves of the write data. The compare looks only at the two enabled lanes.
- R5: The fourth phase writes word offset i with the value i and full enables, then verifies every word. A clean run leaves each word equal to its offset.
- R6: Within a phase, all writes come before any read. At most one read is outstanding, and the next read is issued only after read valid. Read data is taken only when valid is high.
- R7: A phase with a mismatch runs all its reads to the end. The engine then finishes with fail and starts no further phase.
- R8: The first mismatch of a run records its word address, the expected value and the observed value, both masked to the accessed lanes (other lanes zero). Later mismatches leave these outputs unchanged until the next start.
- R9: Done is high for exactly one cycle. Pass is high with done only if all four phases completed with no mismatch. With read latency L cycles and region length W, a clean run raises done 8·W·(2+L)+4 cycles after the start edge.
- R10: A zero-length region finishes at once: done and pass are high in the cycle after the start edge, and no memory access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled in idle |
| base_i | input | AW | Region base word address |
| len_words_i | input | LW | Region length in 32-bit words |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | 32 | Write data, value replicated across lanes |
| mem_be_o | output | 4 | Byte enables, bit n for bits 8n+7..8n |
| mem_we_o | output | 1 | Write strobe, one write per high cycle |
| mem_re_o | output | 1 | Read request strobe |
| mem_rdata_i | input | 32 | Read data |
| mem_rvalid_i | input | 1 | Read data valid |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result, meaningful with done and held until next start |
| fail_addr_o | output | AW | Word address of first mismatch |
| fail_exp_o | output | 32 | Masked expected value at first mismatch |
| fail_obs_o | output | 32 | Masked observed value at first mismatch |

## Verification
A phase with N locations and read latency L takes N write cycles, N·(1+L) read cycles and one decision cycle. Done is therefore due a fixed number of cycles after the start edge, and the bench computes that number from the vector's length, latency and the phase where its model first sees a mismatch. The bench counts falling edges from the start edge and compares the count with that number. All outputs are sampled on falling edges, half a cycle after the edge that changed them. Write address, enables and data are checked on every write cycle against the pattern for the current phase and offset. The captured failure fields are read in the done cycle and again one cycle later.

// File: rtl/mpt_pkg.sv
package mpt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_PH_END,
        ST_FINISH
    } mpt_state_e;

    // Order of the enum is the order the phases run in.
    typedef enum logic [1:0] {
        PH_CHECKER,
        PH_BYTE,
        PH_HALF,
        PH_WORD
    } mpt_phase_e;

    localparam int unsigned LANES = 4;
    localparam int unsigned DW    = 8 * LANES;

    localparam logic [DW-1:0] CHK_EVEN = 32'hAA55_AA55;
    localparam logic [DW-1:0] CHK_ODD  = 32'h55AA_55AA;

    // log2 of locations per word for each phase
    function automatic logic [1:0] loc_shift(mpt_phase_e ph);
        unique case (ph)
            PH_BYTE: return 2'd2;
            PH_HALF: return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/mpt_pattern.sv
module mpt_pattern
    import mpt_pkg::*;
#(
    parameter int unsigned AW = 12,
    parameter int unsigned IW = 10
) (
    input  mpt_phase_e       phase_i,
    input  logic [IW-1:0]    idx_i,
    input  logic [AW-1:0]    base_i,
    output logic [AW-1:0]    addr_o,
    output logic [DW-1:0]    data_o,
    output logic [LANES-1:0] be_o,
    output logic [DW-1:0]    lane_mask_o
);

    logic [IW-1:0] word_idx;

    always_comb begin
        unique case (phase_i)
            PH_CHECKER: begin
                word_idx = idx_i;
                be_o     = '1;
                data_o   = idx_i[0] ? CHK_ODD : CHK_EVEN;
            end
            PH_BYTE: begin
                word_idx = idx_i >> 2;
                be_o     = 4'b0001 << idx_i[1:0];
                data_o   = {LANES{8'(idx_i)}};
            end
            PH_HALF: begin
                word_idx = idx_i >> 1;
                be_o     = idx_i[0] ? 4'b1100 : 4'b0011;
                data_o   = {2{16'(idx_i)}};
            end
            PH_WORD: begin
                word_idx = idx_i;
                be_o     = '1;
                data_o   = DW'(idx_i);
            end
            default: begin
                word_idx = '0;
                be_o     = '0;
                data_o   = '0;
            end
        endcase
    end

    assign addr_o = base_i + AW'(word_idx);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask_o[8*g +: 8] = {8{be_o[g]}};
    end

endmodule

// File: rtl/mpt_err_capture.sv
module mpt_err_capture
    import mpt_pkg::*;
#(
    parameter int unsigned AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          cmp_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] exp_i,
    input  logic [DW-1:0] obs_i,
    output logic          err_o,
    output logic [AW-1:0] first_addr_o,
    output logic [DW-1:0] first_exp_o,
    output logic [DW-1:0] first_obs_o
);

    logic mismatch;
    assign mismatch = cmp_en_i && (exp_i != obs_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_o        <= 1'b0;
            first_addr_o <= '0;
            first_exp_o  <= '0;
            first_obs_o  <= '0;
        end else if (clear_i) begin
            err_o        <= 1'b0;
            first_addr_o <= '0;
            first_exp_o  <= '0;
            first_obs_o  <= '0;
        end else if (mismatch && !err_o) begin
            err_o        <= 1'b1;
            first_addr_o <= addr_i;
            first_exp_o  <= exp_i;
            first_obs_o  <= obs_i;
        end
    end

    AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !clear_i) |=> ($stable(first_addr_o) && $stable(first_exp_o)
                                 && $stable(first_obs_o))); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !clear_i) |=> err_o); // R7

endmodule

// File: rtl/mem_pattern_bist.sv
module mem_pattern_bist
    import mpt_pkg::*;
#(
    parameter int unsigned AW = 12,
    parameter int unsigned LW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [AW-1:0]     base_i,
    input  logic [LW-1:0]     len_words_i,
    output logic [AW-1:0]     mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    output logic [3:0]        mem_be_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    input  logic [31:0]       mem_rdata_i,
    input  logic              mem_rvalid_i,
    output logic              done_o,
    output logic              pass_o,
    output logic [AW-1:0]     fail_addr_o,
    output logic [31:0]       fail_exp_o,
    output logic [31:0]       fail_obs_o
);

    localparam int unsigned IW = LW + 2;

    mpt_state_e    state_q, state_d;
    mpt_phase_e    phase_q;
    logic [IW-1:0] idx_q;
    logic [IW-1:0] loc_count;
    logic [AW-1:0] base_q;
    logic [LW-1:0] len_q;
    logic          pass_q;
    logic          at_last;
    logic          accept;
    logic          cmp_en;
    logic          err;

    logic [DW-1:0] pat_data;
    logic [DW-1:0] lane_mask;
    logic [AW-1:0] pat_addr;
    logic [3:0]    pat_be;

    assign loc_count = IW'(len_q) << loc_shift(phase_q);
    assign at_last   = (idx_q == loc_count - IW'(1));
    assign accept    = (state_q == ST_IDLE) && start_i;
    assign cmp_en    = (state_q == ST_RD_WAIT) && mem_rvalid_i;

    mpt_pattern #(.AW(AW), .IW(IW)) u_pattern (
        .phase_i     (phase_q),
        .idx_i       (idx_q),
        .base_i      (base_q),
        .addr_o      (pat_addr),
        .data_o      (pat_data),
        .be_o        (pat_be),
        .lane_mask_o (lane_mask)
    );

    mpt_err_capture #(.AW(AW)) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (accept),
        .cmp_en_i     (cmp_en),
        .addr_i       (pat_addr),
        .exp_i        (pat_data & lane_mask),
        .obs_i        (mem_rdata_i & lane_mask),
        .err_o        (err),
        .first_addr_o (fail_addr_o),
        .first_exp_o  (fail_exp_o),
        .first_obs_o  (fail_obs_o)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = (len_words_i == '0) ? ST_FINISH : ST_WRITE;
            ST_WRITE:   if (at_last) state_d = ST_RD_REQ;
            ST_RD_REQ:  state_d = ST_RD_WAIT;
            ST_RD_WAIT: if (mem_rvalid_i) state_d = at_last ? ST_PH_END : ST_RD_REQ;
            ST_PH_END:  state_d = (err || phase_q == PH_WORD) ? ST_FINISH : ST_WRITE;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register and sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= PH_CHECKER;
            idx_q   <= '0;
            base_q  <= '0;
            len_q   <= '0;
            pass_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    base_q  <= base_i;
                    len_q   <= len_words_i;
                    phase_q <= PH_CHECKER;
                    idx_q   <= '0;
                    pass_q  <= (len_words_i == '0);
                end
                ST_WRITE:   idx_q <= at_last ? '0 : idx_q + IW'(1);
                ST_RD_WAIT: if (mem_rvalid_i && !at_last) idx_q <= idx_q + IW'(1);
                ST_PH_END: begin
                    pass_q <= !err && (phase_q == PH_WORD);
                    if (!err && phase_q != PH_WORD) begin
                        phase_q <= mpt_phase_e'(phase_q + 2'd1);
                        idx_q   <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_addr_o  = pat_addr;
        mem_wdata_o = pat_data;
        mem_be_o    = pat_be;
        mem_we_o    = (state_q == ST_WRITE);
        mem_re_o    = (state_q == ST_RD_REQ);
        done_o      = (state_q == ST_FINISH);
        pass_o      = pass_q;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && pass_o) |-> !err); // R9

    AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re_o |=> !mem_re_o); // R6

    AST_WAIT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RD_WAIT) && !mem_rvalid_i) |=> !mem_re_o); // R6

    AST_NO_MIXED: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o)); // R6

    AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && phase_q == PH_BYTE) |-> ($countones(mem_be_o) == 1)); // R3

    AST_HALF_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && phase_q == PH_HALF) |-> ($countones(mem_be_o) == 2)); // R4

    AST_STOP_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_PH_END) && err) |=> (done_o && !pass_o)); // R7

endmodule

// File: tb/mem_pattern_bist_tb.sv
module mem_pattern_bist_tb;

    localparam int AW = 12;
    localparam int LW = 8;

    typedef struct packed {
        logic [7:0] base;
        logic [7:0] words;
        logic [3:0] lat;
        logic       fen;
        logic [7:0] w0;
        logic [7:0] w1;
        logic [4:0] fbit;
        logic       fval;
    } vec_t;

    // base, words, latency, fault enable, fault word offsets, bit, stuck value
    localparam vec_t VECS [8] = '{
        '{8'd0,   8'd4, 4'd1, 1'b0, 8'd0, 8'd0, 5'd0,  1'b0},
        '{8'd16,  8'd6, 4'd3, 1'b0, 8'd0, 8'd0, 5'd0,  1'b0},
        '{8'd8,   8'd5, 4'd2, 1'b1, 8'd2, 8'd2, 5'd0,  1'b1},
        '{8'd0,   8'd5, 4'd1, 1'b1, 8'd1, 8'd3, 5'd3,  1'b0},
        '{8'd40,  8'd4, 4'd2, 1'b1, 8'd3, 8'd3, 5'd31, 1'b1},
        '{8'd100, 8'd8, 4'd1, 1'b1, 8'd6, 8'd6, 5'd2,  1'b0},
        '{8'd60,  8'd3, 4'd4, 1'b1, 8'd2, 8'd2, 5'd30, 1'b0},
        '{8'd200, 8'd8, 4'd1, 1'b1, 8'd5, 8'd7, 5'd9,  1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base = '0;
    logic [LW-1:0] len = '0;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [3:0]    mem_be;
    logic          mem_we, mem_re;
    logic [31:0]   mem_rdata;
    logic          mem_rvalid;
    logic          done, pass;
    logic [AW-1:0] fail_addr;
    logic [31:0]   fail_exp, fail_obs;

    always #10 clk = ~clk;

    mem_pattern_bist #(.AW(AW), .LW(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .base_i(base), .len_words_i(len),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_be_o(mem_be),
        .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_rdata_i(mem_rdata),
        .mem_rvalid_i(mem_rvalid), .done_o(done), .pass_o(pass),
        .fail_addr_o(fail_addr), .fail_exp_o(fail_exp), .fail_obs_o(fail_obs)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // ---------------- memory model ----------------
    logic [31:0] mem [256];
    int          lat = 1;
    bit          f_en = 0;
    int          f_w0 = 0, f_w1 = 0, f_bit = 0;
    bit          f_val = 0;
    int          cur_base = 0;
    bit          pend = 0;
    int          pcnt = 0;
    logic [7:0]  raddr = '0;
    int          rd_viol = 0;

    function automatic logic [31:0] faulted(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] r = d;
        if (f_en && (int'(a) == ((cur_base + f_w0) & 255) || int'(a) == ((cur_base + f_w1) & 255)))
            r[f_bit] = f_val;
        return r;
    endfunction

    assign mem_rvalid = pend && (pcnt == 0);
    assign mem_rdata  = mem_rvalid ? faulted(raddr, mem[raddr]) : 32'h0;

    always @(posedge clk) begin
        if (mem_we) begin
            for (int l = 0; l < 4; l++)
                if (mem_be[l]) mem[mem_addr[7:0]][8*l +: 8] <= mem_wdata[8*l +: 8];
        end
        if (mem_re) begin
            if (pend) rd_viol <= rd_viol + 1;
            pend  <= 1'b1;
            pcnt  <= lat - 1;
            raddr <= mem_addr[7:0];
        end else if (pend) begin
            if (pcnt == 0) pend <= 1'b0;
            else pcnt <= pcnt - 1;
        end
    end

    // ---------------- reference pattern ----------------
    task automatic pat_at(input int ph, input int k, input int b,
                          output int waddr, output logic [3:0] be, output logic [31:0] full);
        int wi;
        unique case (ph)
            0: begin wi = k;      be = 4'hF; full = k[0] ? 32'h55AA55AA : 32'hAA55AA55; end
            1: begin wi = k >> 2; be = 4'b0001 << k[1:0]; full = {4{k[7:0]}}; end
            2: begin wi = k >> 1; be = k[0] ? 4'b1100 : 4'b0011; full = {2{k[15:0]}}; end
            default: begin wi = k; be = 4'hF; full = k; end
        endcase
        waddr = b + wi;
    endtask

    function automatic logic [31:0] lmask(input logic [3:0] be);
        logic [31:0] m;
        for (int l = 0; l < 4; l++) m[8*l +: 8] = {8{be[l]}};
        return m;
    endfunction

    // ---------------- write monitor ----------------
    int mon_ph = 0, mon_k = 0, wr_bad = 0, c1 = 0, c2 = 0, c4 = 0;
    bit last_rd = 0;
    int          m_wa;
    logic [3:0]  m_be;
    logic [31:0] m_full;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                if (last_rd) begin mon_ph++; mon_k = 0; end
                pat_at(mon_ph, mon_k, cur_base, m_wa, m_be, m_full);
                if (int'(mem_addr) != m_wa || mem_be != m_be
                    || ((mem_wdata ^ m_full) & lmask(m_be)) != 32'h0) wr_bad++;
                case ($countones(mem_be))
                    1: c1++;
                    2: c2++;
                    4: c4++;
                    default: wr_bad++;
                endcase
                mon_k++;
                last_rd = 0;
            end
            if (mem_re) last_rd = 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- one run ----------------
    task automatic run_vec(input vec_t v, input bit poke);
        int          e_cyc = 0, e_ph = 0, e_addr = 0, e1 = 0, e2 = 0, e4 = 0;
        bit          found = 0;
        logic [31:0] e_exp = 0, e_obs = 0;
        int          cyc;
        int          wa;
        logic [3:0]  be;
        logic [31:0] full, m, o;
        int          words = int'(v.words);
        // reference model of the four phases
        if (words > 0) begin
            for (int p = 0; p < 4; p++) begin
                int n;
                bit ph_err = 0;
                n = words << ((p == 1) ? 2 : (p == 2) ? 1 : 0);
                for (int k = 0; k < n; k++) begin
                    pat_at(p, k, int'(v.base), wa, be, full);
                    m = lmask(be);
                    o = full;
                    if (v.fen && (wa == int'(v.base) + int'(v.w0) || wa == int'(v.base) + int'(v.w1)))
                        o[v.fbit] = v.fval;
                    if ((o & m) != (full & m)) begin
                        ph_err = 1;
                        if (!found) begin
                            found = 1; e_addr = wa; e_exp = full & m; e_obs = o & m;
                        end
                    end
                end
                e_cyc += n * (2 + int'(v.lat)) + 1;
                e_ph++;
                if (p == 1) e1 += n; else if (p == 2) e2 += n; else e4 += n;
                if (ph_err) break;
            end
        end
        lat = int'(v.lat); f_en = v.fen; f_w0 = int'(v.w0); f_w1 = int'(v.w1);
        f_bit = int'(v.fbit); f_val = v.fval; cur_base = int'(v.base);
        mon_ph = 0; mon_k = 0; last_rd = 0; wr_bad = 0; c1 = 0; c2 = 0; c4 = 0;
        @(negedge clk);
        rd_viol = 0;
        base = AW'(v.base); len = v.words; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 60000) begin
            @(negedge clk);
            cyc++;
            start = poke && (cyc == 5);
        end
        start = 1'b0;
        check(cyc == e_cyc, poke ? "R1" : "R9", "done cycle", cyc, e_cyc);
        check(pass == !found, "R9", "pass", pass, !found);
        if (found) begin
            check(int'(fail_addr) == e_addr, "R8", "fail addr", fail_addr, e_addr);
            check(fail_exp == e_exp, "R8", "fail expected", fail_exp, e_exp);
            check(fail_obs == e_obs, "R8", "fail observed", fail_obs, e_obs);
            check((mon_ph + 1) == e_ph, "R7", "phases run", mon_ph + 1, e_ph);
        end
        if (words > 0) begin
            check(wr_bad == 0, "R2", "write addr/enable/data mismatches (R3 R4 R5)", wr_bad, 0);
            check(c1 == e1, "R3", "single-lane writes", c1, e1);
            check(c2 == e2, "R4", "two-lane writes", c2, e2);
            check(c4 == e4, "R2", "four-lane writes", c4, e4);
            check(rd_viol == 0, "R6", "overlapping reads", rd_viol, 0);
        end
        if (!found && words > 0) begin
            int bad = 0;
            for (int i = 0; i < words; i++)
                if (mem[(int'(v.base) + i) & 255] != i) bad++;
            check(bad == 0, "R5", "final word contents", bad, 0);
        end
        @(negedge clk);
        check(!done, "R9", "done one cycle", done, 0);
        check(pass == !found, "R8", "result held", pass, !found);
        if (found) check(int'(fail_addr) == e_addr, "R8", "fail addr held", fail_addr, e_addr);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        check(!done && !pass && !mem_we && !mem_re, "R1", "reset outputs",
              {done, pass, mem_we, mem_re}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_we && !mem_re && !done, "R1", "idle quiet", {mem_we, mem_re, done}, 0);
        foreach (VECS[i]) run_vec(VECS[i], 1'b0);
        // R10: zero-length region
        begin
            int acc = 0;
            vec_t z = '{8'd5, 8'd0, 4'd1, 1'b0, 8'd0, 8'd0, 5'd0, 1'b0};
            run_vec(z, 1'b0);
            check(c1 + c2 + c4 == 0, "R10", "no access on empty region", c1 + c2 + c4, 0);
            acc = tests;
            if (acc == 0) fails++;
        end
        // R1: start while busy has no effect
        run_vec(VECS[3], 1'b1);
        run_vec(VECS[0], 1'b1);
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule